// File: doc/BRIEF.md
# Chip enable reset mode controller

This block sits in the always-on domain beside an external active-low chip-enable button. It takes the already debounced pin level and turns it into a registered system reset request. How it does this depends on a two-bit mode held in its control word. In level mode, reset follows the pin. In interrupt mode, the pin alone never resets the chip, and only a timeout request from the neighbouring press sequencer does. In pulse mode, each newly seen low level fires a short reset.

The control word also holds four timing selections for the debouncer and the press sequencer, and it exposes the current pin level as a read-only bit. Pulse mode is one-way. Once software selects it, the mode reads back as 2'b11 and cannot be changed until the power-on reset input is asserted again. That input stands in for a full power cycle. A reset forced by the sequencer sets the mode back to level reset.

Top module: `cen_rst_mode_ctrl`

## Requirements
- R1: While `por` is high, `sys_rst` is 1 on the following edge. Power-on reset loads mode 00 and timing bits [2:0]=001, with all other timing bits 0. A read of the control word then returns 0x00000001, with the pin level added at bit 18.
- R2: In level mode (mode field [17:16]=00), `sys_rst` one cycle later equals the inverse of `pin_lvl`.
- R3: In interrupt mode (mode field 01), a low or changing `pin_lvl` never asserts `sys_rst`.
- R4: In interrupt mode, `seq_rst_req` asserts `sys_rst` one cycle later and sets the mode field to 00. If the pin is then still low, reset stays asserted until the pin goes high.
- R5: `seq_rst_req` has no effect in level mode or pulse mode: no reset is caused and the mode read stays the same.
- R6: In pulse mode, a high-to-low change of `pin_lvl` makes `sys_rst` high for exactly one cycle. A pin held low does not hold reset.
- R7: Writing a mode value with bit 17 set enters pulse mode, and the field then reads 11. Later writes to the mode field are ignored. Only `por` returns the mode to 00.
- R8: Bit 18 of `rd_data` returns the present `pin_lvl`.
- R9: Bits 31:19, 15:14, 11, 7 and 3 of `rd_data` read 0 whatever was written.
- R10: The timing fields [13:12], [10:8], [6:4] and [2:0] are written on every `wr_en`. They read back and appear on `cfg_timing`, and `irq_mode` is 1 exactly when the mode is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por | input | 1 | Synchronous active-high power-on reset |
| pin_lvl | input | 1 | Debounced chip-enable pin level (0 = pressed) |
| seq_rst_req | input | 1 | Reset request from the press sequencer timeout |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| cfg_timing | output | 32 | Masked timing fields for debouncer and sequencer |
| irq_mode | output | 1 | Interrupt mode active, for the sequencer |
| sys_rst | output | 1 | Registered system reset request |

## Verification
`sys_rst`, the stored mode, the pulse lock and the timing fields all change on the first clock edge after the input that causes them. The pin status bit in `rd_data` follows `pin_lvl` in the same cycle. The bench changes inputs on the falling edge and lets exactly one rising edge pass. It then compares every output on the next falling edge with a model that it updates once for that same edge. This gives each result the one-cycle latency it is due, and the status bit is compared against the pin value still being driven.

// File: rtl/cen_pkg.sv
package cen_pkg;

    localparam int CTRL_W   = 32;
    localparam int MODE_LSB = 16;
    localparam int STAT_BIT = 18;

    localparam logic [CTRL_W-1:0] TIM_MASK    = 32'h0000_3777;
    localparam logic [CTRL_W-1:0] TIM_DEFAULT = 32'h0000_0001;

    typedef enum logic [1:0] {
        CEN_LEVEL = 2'b00,
        CEN_INTR  = 2'b01,
        CEN_PULSE = 2'b11
    } cen_mode_e;

    function automatic cen_mode_e eff_mode(input logic locked, input logic intr);
        if (locked)    return CEN_PULSE;
        else if (intr) return CEN_INTR;
        else           return CEN_LEVEL;
    endfunction

endpackage

// File: rtl/cen_ctrl_reg.sv
module cen_ctrl_reg
    import cen_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              force_level,
    output cen_mode_e         mode,
    output logic [CTRL_W-1:0] timing
);
    logic              intr_q;
    logic              lock_q;
    logic [CTRL_W-1:0] tim_q;

    always_ff @(posedge clk) begin
        if (por) begin
            intr_q <= 1'b0;
            lock_q <= 1'b0;
            tim_q  <= TIM_DEFAULT;
        end else begin
            if (force_level) begin
                intr_q <= 1'b0;
            end else if (wr_en && !lock_q) begin
                intr_q <= wr_data[MODE_LSB] & ~wr_data[MODE_LSB+1];
                lock_q <= wr_data[MODE_LSB+1];
            end
            if (wr_en) begin
                tim_q <= wr_data & TIM_MASK;
            end
        end
    end

    assign mode   = eff_mode(lock_q, intr_q);
    assign timing = tim_q;

    // R7: pulse lock only leaves through power-on reset
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (por)
        (mode == CEN_PULSE) |=> (mode == CEN_PULSE));

    // R4: forced reset returns the mode to level
    a_r4_force_level: assert property (@(posedge clk) disable iff (por)
        force_level |=> (mode == CEN_LEVEL));

endmodule

// File: rtl/cen_rst_gen.sv
module cen_rst_gen
    import cen_pkg::*;
(
    input  logic      clk,
    input  logic      por,
    input  cen_mode_e mode,
    input  logic      pin_lvl,
    input  logic      seq_rst_req,
    output logic      force_level,
    output logic      sys_rst
);
    logic pin_prev_q;
    logic rst_q;
    logic rst_d;

    assign force_level = seq_rst_req && (mode == CEN_INTR);

    always_comb begin
        if (force_level) begin
            rst_d = 1'b1;
        end else begin
            unique case (mode)
                CEN_LEVEL: rst_d = ~pin_lvl;
                CEN_PULSE: rst_d = pin_prev_q & ~pin_lvl;
                default:   rst_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            pin_prev_q <= 1'b1;
            rst_q      <= 1'b1;
        end else begin
            pin_prev_q <= pin_lvl;
            rst_q      <= rst_d;
        end
    end

    assign sys_rst = rst_q;

    // R2: level mode follows a low pin
    a_r2_level_low: assert property (@(posedge clk) disable iff (por)
        (mode == CEN_LEVEL && !pin_lvl) |=> sys_rst);

    // R3: pin alone never resets in interrupt mode
    a_r3_no_pin_reset: assert property (@(posedge clk) disable iff (por)
        (mode == CEN_INTR && !seq_rst_req) |=> !sys_rst);

    // R4: sequencer timeout resets in interrupt mode
    a_r4_forced_rst: assert property (@(posedge clk) disable iff (por)
        (mode == CEN_INTR && seq_rst_req) |=> sys_rst);

    // R6: pulse mode reset lasts a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (por)
        (mode == CEN_PULSE && sys_rst) |=> !sys_rst);

endmodule

// File: rtl/cen_rst_mode_ctrl.sv
module cen_rst_mode_ctrl
    import cen_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              pin_lvl,
    input  logic              seq_rst_req,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic [CTRL_W-1:0] cfg_timing,
    output logic              irq_mode,
    output logic              sys_rst
);
    cen_mode_e         mode;
    logic              force_level;
    logic [CTRL_W-1:0] timing;

    cen_ctrl_reg u_reg (
        .clk         (clk),
        .por         (por),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .force_level (force_level),
        .mode        (mode),
        .timing      (timing)
    );

    cen_rst_gen u_rst (
        .clk         (clk),
        .por         (por),
        .mode        (mode),
        .pin_lvl     (pin_lvl),
        .seq_rst_req (seq_rst_req),
        .force_level (force_level),
        .sys_rst     (sys_rst)
    );

    always_comb begin
        rd_data                          = timing;
        rd_data[MODE_LSB+1:MODE_LSB]     = mode;
        rd_data[STAT_BIT]                = pin_lvl;
    end

    assign cfg_timing = timing;
    assign irq_mode   = (mode == CEN_INTR);

    // R9: reserved bits stay zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (por)
        ((rd_data & ~(TIM_MASK | 32'h0007_0000)) == '0));

endmodule

// File: tb/cen_rst_mode_ctrl_tb.sv
module cen_rst_mode_ctrl_tb_top;
    import cen_pkg::*;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        pin_lvl = 1'b1;
    logic        seq_rst_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] cfg_timing;
    logic        irq_mode;
    logic        sys_rst;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;

    // bench model
    logic [1:0]  m_mode = 2'b00;
    logic        m_lock = 1'b0;
    logic [31:0] m_tim  = 32'h1;
    logic        m_rst  = 1'b1;
    logic        m_prev = 1'b1;

    always #10 clk = ~clk;

    cen_rst_mode_ctrl dut_i (
        .clk(clk), .por(por), .pin_lvl(pin_lvl), .seq_rst_req(seq_rst_req),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cfg_timing(cfg_timing), .irq_mode(irq_mode), .sys_rst(sys_rst)
    );

    function automatic logic [1:0] read_mode();
        return m_lock ? 2'b11 : m_mode;
    endfunction

    function automatic logic [31:0] exp_rd();
        return (m_tim & 32'h3777) | (32'(read_mode()) << 16) | (32'(pin_lvl) << 18);
    endfunction

    function automatic string mode_tag();
        if (m_lock)             return "R6";
        else if (m_mode == 2'b01) return "R3";
        else                    return "R2";
    endfunction

    task automatic model_edge();
        logic forced;
        if (por) begin
            m_mode = 2'b00; m_lock = 1'b0; m_tim = 32'h1; m_rst = 1'b1; m_prev = 1'b1;
        end else begin
            forced = seq_rst_req && !m_lock && (m_mode == 2'b01);
            if (forced)                m_rst = 1'b1;
            else if (m_lock)           m_rst = m_prev && !pin_lvl;
            else if (m_mode == 2'b00)  m_rst = !pin_lvl;
            else                       m_rst = 1'b0;
            m_prev = pin_lvl;
            if (forced) m_mode = 2'b00;
            else if (wr_en && !m_lock) begin
                m_mode = wr_data[17:16];
                if (wr_data[17]) m_lock = 1'b1;
            end
            if (wr_en) m_tim = wr_data & 32'h3777;
        end
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (sys_rst !== m_rst) begin
            n_fail++;
            $display("FAIL %s sys_rst actual %0b expected %0b", tag, sys_rst, m_rst);
        end
        n_chk++;
        if (rd_data !== exp_rd()) begin
            n_fail++;
            $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, exp_rd());
        end
        n_chk++;
        if (cfg_timing !== (m_tim & 32'h3777) || irq_mode !== (!m_lock && m_mode == 2'b01)) begin
            n_fail++;
            $display("FAIL R10 cfg/irq actual %h/%0b expected %h/%0b", cfg_timing, irq_mode,
                     m_tim & 32'h3777, (!m_lock && m_mode == 2'b01));
        end
    endtask

    task automatic step(input logic p, input logic pin, input logic seq,
                        input logic w, input logic [31:0] d, input string tag);
        por = p; pin_lvl = pin; seq_rst_req = seq; wr_en = w; wr_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, '0, "R1");
        step(0, 1, 0, 0, '0, "R1");
        // R2 level mode and R8 status
        step(0, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, '0, "R8");
        step(0, 1, 0, 0, '0, "R2");
        // R5 seq ignored in level mode
        step(0, 1, 1, 0, '0, "R5");
        // R9 R10 write all ones except pulse bit: interrupt mode
        step(0, 1, 0, 1, 32'hFFFD_FFFF, "R9");
        // R3 pin low held in interrupt mode
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, '0, "R3");
        // R4 forced reset with pin low holds until high
        step(0, 0, 1, 0, '0, "R4");
        step(0, 0, 0, 0, '0, "R4");
        step(0, 1, 0, 0, '0, "R4");
        step(0, 1, 0, 0, '0, "R4");
        // R4 forced reset with pin high lasts one cycle
        step(0, 1, 0, 1, 32'h0001_0123, "R10");
        step(0, 1, 1, 0, '0, "R4");
        step(0, 1, 0, 0, '0, "R4");
        // R7 enter pulse with 10
        step(0, 1, 0, 1, 32'h0002_0000, "R7");
        step(0, 1, 0, 1, 32'h0000_0000, "R7");
        step(0, 1, 0, 1, 32'h0001_0000, "R7");
        // R6 pulse on falling edge, low held no reset
        step(0, 0, 0, 0, '0, "R6");
        step(0, 0, 0, 0, '0, "R6");
        step(0, 0, 0, 0, '0, "R6");
        step(0, 1, 1, 0, '0, "R5");
        step(0, 1, 1, 0, '0, "R5");
        // R7 por clears
        step(1, 1, 0, 0, '0, "R7");
        step(0, 1, 0, 0, '0, "R7");

        // constrained random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic p, pin, seq, w;
            logic [31:0] d;
            p   = ($urandom_range(0, 299) == 0);
            pin = ($urandom_range(0, 5) == 0) ? ~pin_lvl : pin_lvl;
            seq = ($urandom_range(0, 9) == 0);
            w   = ($urandom_range(0, 7) == 0);
            d   = $urandom();
            if ($urandom_range(0, 7) != 0) d[17] = 1'b0;
            step(p, pin, seq, w, d, mode_tag());
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule